// File: doc/BRIEF.md
# Eight-Line Nested Interrupt Priority Resolver

This block collects eight interrupt request lines into a pending register and filters them through a mask register. It then decides whether the best remaining request may interrupt the processor. That decision depends on what is already being serviced and on the nesting policy in force. In the fully nested policy a request must outrank every active service level. In the special fully nested policy a request may also match the top active level. In special mask operation only the lines already in service are held back, whatever their level.

The processor answers a raised `intReq` with a one-cycle acknowledge strobe. The resolver then moves the winning line from pending to in service and presents a vector: an eight-aligned base plus the line number. A one-cycle end-of-interrupt strobe retires the most urgent in-service line, and the interrupt output is recomputed from the updated state.

The nesting policy and the vector base are loaded together through a configuration write. Special mask operation is a level input that can change at any time.

Top module: `irqResolver`

## Requirements
- R1: After reset `intReq` and `vecValid` are 0, the in-service set is empty and all eight lines are masked, so a request that arrives before the first mask write does not raise `intReq`.
- R2: A request on a masked line (mask bit 1 = masked) never raises `intReq` but stays pending; clearing its mask bit later raises `intReq` without the line being driven again.
- R3: Line 0 is the most urgent and line 7 the least; among the eligible unmasked pending lines the lowest index wins, and the vector is the stored base plus that index.
- R4: A configuration write stores the base with its three low bits forced to 0, so vector bits [2:0] always equal the winning line index.
- R5: In fully nested operation (`cfgSpecialNested` = 0, `specialMaskOn` = 0) `intReq` is 1 only when the winner's index is strictly lower than the lowest in-service index, or nothing is in service.
- R6: In special fully nested operation (`cfgSpecialNested` = 1) a winner whose index equals the lowest in-service index is also forwarded; a higher index is not.
- R7: With `specialMaskOn` = 1, lines that are in service are excluded from arbitration, and any other pending unmasked line is forwarded regardless of level.
- R8: `specialMaskOn` may change at any time and affects `intReq` in the same cycle, without a reset or configuration write.
- R9: An end-of-interrupt strobe clears the lowest-index set in-service bit, and `intReq` reflects the new in-service set from the following cycle.
- R10: An acknowledge strobe while `intReq` is 0 has no effect: `vecValid` stays 0 and no pending or in-service state changes.
- R11: An acknowledge strobe while `intReq` is 1 clears the winner's pending bit and sets its in-service bit. In the next cycle it drives `vecValid` to 1 for one cycle, with the vector on `vecOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 8 | Request lines, sampled each clock into the pending register |
| maskWrEn | input | 1 | Load `maskWrData` into the mask register |
| maskWrData | input | 8 | Mask value, 1 blocks the line |
| cfgWrEn | input | 1 | Load vector base and nesting policy |
| cfgBase | input | 8 | Vector base, low three bits dropped |
| cfgSpecialNested | input | 1 | 1 selects special fully nested, 0 fully nested |
| specialMaskOn | input | 1 | Run-time special mask enable |
| ackStrobe | input | 1 | Interrupt acknowledge, one cycle |
| eoiStrobe | input | 1 | End of interrupt, one cycle |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector of the last acknowledged line |
| vecValid | output | 1 | One-cycle qualifier for `vecOut` |

## Verification
The assertions check on every cycle that `intReq` only appears with an unmasked pending line. They also check that in fully nested operation a forwarded winner strictly outranks service, and that in special mask operation the winner is never in service. Further checks cover the vector and its qualifier, which must follow each accepted acknowledge and nothing else, and the end-of-interrupt strobe, which must retire exactly one in-service line. Only the bench scenarios show the full ordering. A sweep over every request pattern and every mask value checks lowest-index priority and the retained pending bits. Directed sequences show the differences between the three nesting policies, the run-time toggling of special mask, and base alignment.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int NumLines = 8;
  localparam int VecWidth = 8;

  typedef struct packed {
    logic ackFire;
    logic eoiFire;
    logic maskLoad;
    logic cfgLoad;
  } ctlStrobes_t;
endpackage

// File: rtl/irqPrioEnc.sv
module irqPrioEnc #(
  parameter int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vecIn,
  output logic             anySet,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     oneHot
);
  always_comb begin
    idx    = '0;
    anySet = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vecIn[i]) begin
        idx    = IDX_W'(i);
        anySet = 1'b1;
      end
    end
    oneHot = '0;
    if (anySet) oneHot[idx] = 1'b1;
  end
endmodule

// File: rtl/irqControl.sv
module irqControl (
  input  logic                ackStrobe,
  input  logic                eoiStrobe,
  input  logic                maskWrEn,
  input  logic                cfgWrEn,
  input  logic                intReq,
  input  logic                isrAny,
  output irqPkg::ctlStrobes_t strobes
);
  always_comb begin
    strobes.ackFire  = ackStrobe & intReq;
    strobes.eoiFire  = eoiStrobe & isrAny;
    strobes.maskLoad = maskWrEn;
    strobes.cfgLoad  = cfgWrEn;
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqPkg::ctlStrobes_t  strobes,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic [VEC_W-1:0]     cfgBase,
  input  logic                 cfgSpecialNested,
  input  logic                 specialMaskOn,
  output logic                 intReq,
  output logic                 isrAny,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  localparam logic [VEC_W-1:0] LowMask = VEC_W'((1 << IDX_W) - 1);

  logic [NUM_LINES-1:0] irrQ, imrQ, isrQ;
  logic [VEC_W-1:0]     baseQ;
  logic                 sfnQ;

  logic [NUM_LINES-1:0] candidate, winOh, topOh, ackClr, eoiClr;
  logic [IDX_W-1:0]     winIdx, topIdx;
  logic                 winAny;

  // eligible lines: pending, unmasked, and not in service under special mask
  assign candidate = irrQ & ~imrQ & (specialMaskOn ? ~isrQ : {NUM_LINES{1'b1}});

  irqPrioEnc #(.N(NUM_LINES)) u_winEnc (
    .vecIn(candidate), .anySet(winAny), .idx(winIdx), .oneHot(winOh)
  );

  irqPrioEnc #(.N(NUM_LINES)) u_topEnc (
    .vecIn(isrQ), .anySet(isrAny), .idx(topIdx), .oneHot(topOh)
  );

  always_comb begin
    if (!winAny)            intReq = 1'b0;
    else if (specialMaskOn) intReq = 1'b1;
    else if (!isrAny)       intReq = 1'b1;
    else if (sfnQ)          intReq = (winIdx <= topIdx);
    else                    intReq = (winIdx < topIdx);
  end

  assign ackClr = strobes.ackFire ? winOh : '0;
  assign eoiClr = strobes.eoiFire ? topOh : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ     <= '0;
      imrQ     <= '1;
      isrQ     <= '0;
      baseQ    <= '0;
      sfnQ     <= 1'b0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      irrQ     <= (irrQ | reqIn) & ~ackClr;
      isrQ     <= (isrQ & ~eoiClr) | ackClr;
      vecValid <= strobes.ackFire;
      if (strobes.ackFire)  vecOut <= baseQ | {{(VEC_W-IDX_W){1'b0}}, winIdx};
      if (strobes.maskLoad) imrQ   <= maskWrData;
      if (strobes.cfgLoad) begin
        baseQ <= cfgBase & ~LowMask;
        sfnQ  <= cfgSpecialNested;
      end
    end
  end

  // R2: interrupt only with an unmasked pending line behind it
  a_r2_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((irrQ & ~imrQ) != '0));

  // R5: fully nested forwards only strictly more urgent lines
  a_r5_fn_strict: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !specialMaskOn && !sfnQ && isrAny) |-> (winIdx < topIdx));

  // R7: special mask never forwards a line already in service
  a_r7_sm_skips_isr: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && specialMaskOn) |-> !isrQ[winIdx]);

  // R11: accepted acknowledge yields vector and in-service bit next cycle
  a_r11_vec_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackFire |=> (vecValid && isrQ[$past(winIdx)]));

  // R4: low vector bits equal the acknowledged line
  a_r4_vec_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackFire |=> (vecOut[IDX_W-1:0] == $past(winIdx)));

  // R10: no vector qualifier without an accepted acknowledge
  a_r10_no_vec_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ackFire |=> !vecValid);

  // R9: end of interrupt retires exactly one in-service line
  a_r9_eoi_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eoiFire && !strobes.ackFire) |=>
      ($countones(isrQ) == $countones($past(isrQ)) - 1));
endmodule

// File: rtl/irqResolver.sv
module irqResolver (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] reqIn,
  input  logic       maskWrEn,
  input  logic [7:0] maskWrData,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgBase,
  input  logic       cfgSpecialNested,
  input  logic       specialMaskOn,
  input  logic       ackStrobe,
  input  logic       eoiStrobe,
  output logic       intReq,
  output logic [7:0] vecOut,
  output logic       vecValid
);
  irqPkg::ctlStrobes_t strobes;
  logic                isrAny;

  irqControl u_ctl (
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe), .maskWrEn(maskWrEn),
    .cfgWrEn(cfgWrEn), .intReq(intReq), .isrAny(isrAny), .strobes(strobes)
  );

  irqDatapath #(.NUM_LINES(irqPkg::NumLines), .VEC_W(irqPkg::VecWidth)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqIn(reqIn),
    .maskWrData(maskWrData), .cfgBase(cfgBase),
    .cfgSpecialNested(cfgSpecialNested), .specialMaskOn(specialMaskOn),
    .intReq(intReq), .isrAny(isrAny), .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: tb/irqResolver_tb.sv
`timescale 1ns/1ps
module irqResolver_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       maskWrEn = 1'b0;
  logic [7:0] maskWrData = '0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgBase = '0;
  logic       cfgSpecialNested = 1'b0;
  logic       specialMaskOn = 1'b0;
  logic       ackStrobe = 1'b0;
  logic       eoiStrobe = 1'b0;
  logic       intReq;
  logic [7:0] vecOut;
  logic       vecValid;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;
  localparam logic [7:0] ExpBase = 8'h48;

  always #4 clk = ~clk;

  irqResolver u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .cfgWrEn(cfgWrEn), .cfgBase(cfgBase),
    .cfgSpecialNested(cfgSpecialNested), .specialMaskOn(specialMaskOn),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe), .intReq(intReq),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doCfg(input logic [7:0] base, input logic sfn);
    @(negedge clk) begin cfgWrEn = 1'b1; cfgBase = base; cfgSpecialNested = sfn; end
    @(negedge clk) cfgWrEn = 1'b0;
  endtask

  task automatic setMask(input logic [7:0] m);
    @(negedge clk) begin maskWrEn = 1'b1; maskWrData = m; end
    @(negedge clk) maskWrEn = 1'b0;
  endtask

  task automatic pulseReq(input logic [7:0] p);
    @(negedge clk) reqIn = p;
    @(negedge clk) reqIn = '0;
  endtask

  task automatic doAck();
    @(negedge clk) ackStrobe = 1'b1;
    @(negedge clk) ackStrobe = 1'b0;
  endtask

  task automatic doEoi();
    @(negedge clk) eoiStrobe = 1'b1;
    @(negedge clk) eoiStrobe = 1'b0;
  endtask

  // fully nested drain: ack then EOI each pending line, lowest index first
  task automatic drain(input logic [7:0] pend, input string tag);
    for (int i = 0; i < 8; i++) begin
      if (pend[i]) begin
        chk({tag, " R3 intReq"}, intReq, 1);
        doAck();
        chk({tag, " R11 vecValid"}, vecValid, 1);
        chk({tag, " R3/R4 vector"}, vecOut, ExpBase + i);
        doEoi();
      end
    end
    chk({tag, " R9 idle after drain"}, intReq, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    resetDut();
    // R1 reset state
    chk("R1 intReq at reset", intReq, 0);
    chk("R1 vecValid at reset", vecValid, 0);
    pulseReq(8'h01);
    chk("R1 all masked after reset", intReq, 0);

    // R4 base with low bits set, R2 pending survives mask
    doCfg(8'h4D, 1'b0);
    setMask(8'h00);
    chk("R2 pending raised on unmask", intReq, 1);
    drain(8'h01, "R2 first");

    // R10 ack with nothing pending
    doAck();
    chk("R10 no vecValid", vecValid, 0);
    chk("R10 no intReq", intReq, 0);
    pulseReq(8'h10);
    drain(8'h10, "R10 state intact");

    // R3 exhaustive request patterns
    for (int p = 1; p < 256; p++) begin
      pulseReq(8'(p));
      drain(8'(p), "R3 sweep");
    end

    // R2 exhaustive masks
    for (int m = 0; m < 256; m++) begin
      logic [7:0] open, rest;
      int w;
      open = ~8'(m);
      setMask(8'(m));
      pulseReq(8'hFF);
      chk("R2 masked intReq", intReq, (open != 0) ? 1 : 0);
      rest = 8'hFF;
      if (open != 0) begin
        w = 0;
        while (!open[w]) w++;
        doAck();
        chk("R2 masked winner", vecOut, ExpBase + w);
        doEoi();
        rest[w] = 1'b0;
      end else begin
        doAck();
        chk("R10 ack while all masked", vecValid, 0);
      end
      setMask(8'h00);
      drain(rest, "R2 pending kept");
    end

    // R5 fully nested
    pulseReq(8'h08);
    doAck();
    chk("R5 ack line3", vecOut, ExpBase + 3);
    pulseReq(8'h08);
    chk("R5 equal blocked", intReq, 0);
    pulseReq(8'h20);
    chk("R5 lower blocked", intReq, 0);
    pulseReq(8'h02);
    chk("R5 higher forwarded", intReq, 1);
    doAck();
    chk("R5 ack line1", vecOut, ExpBase + 1);
    doEoi();
    chk("R9 eoi clears line1 only", intReq, 0);
    doEoi();
    chk("R9 eoi clears line3", intReq, 1);
    drain(8'h28, "R5 tail");

    // R6 special fully nested
    resetDut();
    doCfg(ExpBase, 1'b1);
    setMask(8'h00);
    pulseReq(8'h08);
    doAck();
    pulseReq(8'h08);
    chk("R6 equal forwarded", intReq, 1);
    doAck();
    chk("R6 equal vector", vecOut, ExpBase + 3);
    pulseReq(8'h20);
    chk("R6 lower blocked", intReq, 0);
    doEoi();
    chk("R6 after eoi", intReq, 1);
    doAck();
    chk("R6 lower vector", vecOut, ExpBase + 5);
    doEoi();
    chk("R6 idle", intReq, 0);

    // R7 / R8 special mask
    resetDut();
    doCfg(ExpBase, 1'b0);
    setMask(8'h00);
    pulseReq(8'h08);
    doAck();
    pulseReq(8'h20);
    chk("R7 fully nested blocks lower", intReq, 0);
    specialMaskOn = 1'b1;
    #1;
    chk("R8 special mask on at run time", intReq, 1);
    doAck();
    chk("R7 lower forwarded", vecOut, ExpBase + 5);
    pulseReq(8'h08);
    chk("R7 in-service line blocked", intReq, 0);
    pulseReq(8'h10);
    chk("R7 other line forwarded", intReq, 1);
    @(negedge clk) specialMaskOn = 1'b0;
    #1;
    chk("R8 special mask off at run time", intReq, 0);

    finishRun();
  end
endmodule